// File: doc/BRIEF.md
# Single-Segment Memory DMA Engine

This engine moves one contiguous buffer between system memory and the data port of a storage-card host. Software programs a transfer mode, a 64-bit start address (written as two 32-bit words) and a per-channel run state through a small word-indexed register port, presents a byte count on a length input, then writes the start bit. The engine then issues one memory beat at a time on a request/acknowledge interface. Each beat is as wide as the selected access size. On every acknowledged beat, data passes between memory and the card-side port.

The direction picks one of two channels. Channel 0 carries memory-to-device traffic and channel 1 carries device-to-memory traffic. Each channel has an active-low soft reset bit. Clearing the bit of the running channel aborts the transfer at once. The engine signals completion with a single-cycle pulse and then waits for the next start.

Top module: `seg_dma`

## Requirements
- R1: Register index 0 (mode) bits [17:16] hold the direction field, and only bit 16 is decoded. 0 moves memory to device (mem_we low) and 1 moves device to memory (mem_we high). The field reads back as written.
- R2: Mode bits [5:4] select the access size. Codes 0, 1, 2 and 3 drive mem_size with the same code and step the address by 1, 2, 4 or 8 bytes after each acknowledged beat.
- R3: When mode bit 0 is 1, the address advances after each acknowledged beat. When it is 0, every beat of the transfer uses the start address.
- R4: Writing 1 to bit 0 of register index 1 (control) starts a transfer, and mem_req is high from the next cycle. The control register always reads 0.
- R5: A transfer makes ceil(len/size) acknowledged beats, where len is xfer_len sampled at start. done is high for exactly one cycle after the final acknowledge, and busy and mem_req are low in that cycle. A zero length gives the done pulse with no request.
- R6: A start written while a transfer runs is ignored. Direction, size, address and length stay those of the running transfer.
- R7: Register index 2 bit 8 (channel 0) and bit 9 (channel 1) hold their channel in reset while 0. Both reset to 1. A start for a channel held in reset is ignored. Clearing the running channel's bit ends the transfer within one cycle with no done pulse.
- R8: Register indices 3 and 4 hold the low and high 32-bit words of the start address. Both read back and both reset to 0.
- R9: A start whose address is not a multiple of the access size is ignored. No request and no done pulse follow.
- R10: On an acknowledged memory-to-device beat, dev_valid is high and dev_data equals mem_rdata. On an acknowledged device-to-memory beat, dev_take is high and mem_wdata equals dev_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| xfer_len | input | 16 | Transfer byte count, sampled at start |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat writes memory |
| mem_addr | output | 64 | Beat byte address |
| mem_size | output | 2 | Beat size code |
| mem_wdata | output | 64 | Write data to memory |
| mem_ack | input | 1 | Beat accepted |
| mem_rdata | input | 64 | Read data from memory |
| dev_valid | output | 1 | Data offered to device port |
| dev_data | output | 64 | Data to device port |
| dev_take | output | 1 | Data taken from device port |
| dev_rdata | input | 64 | Data from device port |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A register write takes effect at the clock edge that samples it. A start therefore shows busy and mem_req in the next cycle, and a channel-reset write stops the engine one edge later. The data pass-through outputs follow mem_ack in the same cycle, so the bench drives the acknowledge half a cycle before the edge and reads the port data right after driving it. The done pulse comes in the cycle after the last acknowledged edge. The bench samples it at the falling edge that follows, and checks it has dropped one cycle later.

// File: rtl/seg_dma_pkg.sv
package seg_dma_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 64;
    localparam int DATA_W = 64;
    localparam int IDX_W  = 3;

    localparam logic [IDX_W-1:0] IDX_MODE  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_CHRST = 3'd2;
    localparam logic [IDX_W-1:0] IDX_ADRL  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_ADRH  = 3'd4;

    localparam int NUM_CHAN   = 2;
    localparam int CHRST_LSB  = 8;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } size_e;

    typedef struct packed {
        logic [1:0] dir_field;
        size_e      size;
        logic       inc;
    } mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    function automatic logic [3:0] step_bytes(size_e s);
        return 4'd1 << s;
    endfunction

    function automatic logic addr_ok(logic [ADDR_W-1:0] a, size_e s);
        logic [2:0] m;
        m = 3'(step_bytes(s) - 4'd1);
        return (a[2:0] & m) == 3'd0;
    endfunction

endpackage

// File: rtl/seg_dma_regs.sv
module seg_dma_regs
    import seg_dma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    output mode_t                mode,
    output logic [ADDR_W-1:0]    base_addr,
    output logic [NUM_CHAN-1:0]  chan_run,
    output logic                 start_req
);

    logic [REG_W-1:0] addr_lo_q, addr_hi_q;
    mode_t            mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            addr_lo_q <= '0;
            addr_hi_q <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                IDX_MODE: begin
                    mode_q.dir_field <= cfg_wdata[17:16];
                    mode_q.size      <= size_e'(cfg_wdata[5:4]);
                    mode_q.inc       <= cfg_wdata[0];
                end
                IDX_ADRL: addr_lo_q <= cfg_wdata;
                IDX_ADRH: addr_hi_q <= cfg_wdata;
                default: ;
            endcase
        end
    end

    // one active-low run bit per channel, released out of reset
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        logic run_q;
        always_ff @(posedge clk) begin
            if (rst)
                run_q <= 1'b1;
            else if (cfg_we && cfg_addr == IDX_CHRST)
                run_q <= cfg_wdata[CHRST_LSB + c];
        end
        assign chan_run[c] = run_q;
    end

    assign mode      = mode_q;
    assign base_addr = {addr_hi_q, addr_lo_q};
    assign start_req = cfg_we && (cfg_addr == IDX_CTRL) && cfg_wdata[0];

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            IDX_MODE: begin
                cfg_rdata[17:16] = mode_q.dir_field;
                cfg_rdata[5:4]   = mode_q.size;
                cfg_rdata[0]     = mode_q.inc;
            end
            IDX_CHRST: cfg_rdata[CHRST_LSB +: NUM_CHAN] = chan_run;
            IDX_ADRL:  cfg_rdata = addr_lo_q;
            IDX_ADRH:  cfg_rdata = addr_hi_q;
            default:   cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/seg_dma_mover.sv
module seg_dma_mover
    import seg_dma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mode_t                mode,
    input  logic [ADDR_W-1:0]    base_addr,
    input  logic [NUM_CHAN-1:0]  chan_run,
    input  logic                 start_req,
    input  logic [LEN_W-1:0]     xfer_len,
    input  logic                 mem_ack,
    output logic                 mem_req,
    output logic                 run_dir,
    output logic                 run_inc,
    output size_e                run_size,
    output logic [ADDR_W-1:0]    cur_addr,
    output logic                 busy,
    output logic                 done
);

    run_state_e       state_q;
    logic [LEN_W-1:0] remain_q;
    logic [ADDR_W-1:0] addr_q;
    logic             dir_q, inc_q, done_q;
    size_e            size_q;
    logic [LEN_W-1:0] step_len;
    logic             start_ok;

    assign step_len = LEN_W'(step_bytes(size_q));
    assign start_ok = start_req && (state_q == ST_IDLE)
                      && chan_run[mode.dir_field[0]]
                      && addr_ok(base_addr, mode.size);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            addr_q   <= '0;
            dir_q    <= 1'b0;
            inc_q    <= 1'b0;
            size_q   <= SZ_8;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        if (xfer_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q  <= ST_RUN;
                            remain_q <= xfer_len;
                            addr_q   <= base_addr;
                            dir_q    <= mode.dir_field[0];
                            inc_q    <= mode.inc;
                            size_q   <= mode.size;
                        end
                    end
                end
                ST_RUN: begin
                    if (!chan_run[dir_q]) begin
                        state_q <= ST_IDLE;
                    end else if (mem_ack) begin
                        if (remain_q <= step_len) begin
                            state_q  <= ST_IDLE;
                            remain_q <= '0;
                            done_q   <= 1'b1;
                        end else begin
                            remain_q <= remain_q - step_len;
                        end
                        if (inc_q)
                            addr_q <= addr_q + ADDR_W'(step_bytes(size_q));
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q == ST_RUN);
    assign mem_req  = busy;
    assign run_dir  = dir_q;
    assign run_inc  = inc_q;
    assign run_size = size_q;
    assign cur_addr = addr_q;
    assign done     = done_q;

endmodule

// File: rtl/seg_dma_port.sv
module seg_dma_port
    import seg_dma_pkg::*;
(
    input  logic              mem_req,
    input  logic              mem_ack,
    input  logic              run_dir,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dev_valid,
    output logic [DATA_W-1:0] dev_data,
    output logic              dev_take
);

    logic beat;
    assign beat      = mem_req && mem_ack;
    assign dev_valid = beat && !run_dir;
    assign dev_take  = beat && run_dir;
    assign dev_data  = mem_rdata;
    assign mem_wdata = dev_rdata;

endmodule

// File: rtl/seg_dma.sv
module seg_dma
    import seg_dma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [LEN_W-1:0]   xfer_len,
    output logic               mem_req,
    output logic               mem_we,
    output logic [63:0]        mem_addr,
    output logic [1:0]         mem_size,
    output logic [63:0]        mem_wdata,
    input  logic               mem_ack,
    input  logic [63:0]        mem_rdata,
    output logic               dev_valid,
    output logic [63:0]        dev_data,
    output logic               dev_take,
    input  logic [63:0]        dev_rdata,
    output logic               busy,
    output logic               done
);

    mode_t                mode;
    logic [ADDR_W-1:0]    base_addr;
    logic [NUM_CHAN-1:0]  chan_run;
    logic                 start_req;
    logic                 run_dir;
    logic                 run_inc;
    size_e                run_size;

    seg_dma_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mode      (mode),
        .base_addr (base_addr),
        .chan_run  (chan_run),
        .start_req (start_req)
    );

    seg_dma_mover #(.LEN_W(LEN_W)) u_mover (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .base_addr (base_addr),
        .chan_run  (chan_run),
        .start_req (start_req),
        .xfer_len  (xfer_len),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .run_dir   (run_dir),
        .run_inc   (run_inc),
        .run_size  (run_size),
        .cur_addr  (mem_addr),
        .busy      (busy),
        .done      (done)
    );

    seg_dma_port u_port (
        .mem_req   (mem_req),
        .mem_ack   (mem_ack),
        .run_dir   (run_dir),
        .mem_rdata (mem_rdata),
        .dev_rdata (dev_rdata),
        .mem_wdata (mem_wdata),
        .dev_valid (dev_valid),
        .dev_data  (dev_data),
        .dev_take  (dev_take)
    );

    assign mem_we   = run_dir;
    assign mem_size = run_size;

endmodule

// File: rtl/seg_dma_checker.sv
module seg_dma_checker (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [63:0] mem_addr,
    input logic [1:0]  mem_size,
    input logic        run_inc,
    input logic        busy,
    input logic        done
);

    logic [63:0] step;
    assign step = 64'd1 << mem_size;

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mem_req));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && run_inc) |=>
            (!mem_req || mem_addr == $past(mem_addr) + (64'd1 << $past(mem_size))));

    p_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !run_inc) |=> (!mem_req || $stable(mem_addr)));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (!mem_req || $stable(mem_addr)));

    p_size_stable_r6: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(mem_size)));

    p_aligned_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ((mem_addr & (step - 64'd1)) == 64'd0));

endmodule

bind seg_dma seg_dma_checker u_checker (
    .clk      (clk),
    .rst      (rst),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_size (mem_size),
    .run_inc  (run_inc),
    .busy     (busy),
    .done     (done)
);

// File: tb/seg_dma_bench.sv
module seg_dma_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic [LEN_W-1:0]  xfer_len = '0;
    logic              mem_req, mem_we;
    logic [63:0]       mem_addr;
    logic [1:0]        mem_size;
    logic [63:0]       mem_wdata;
    logic              mem_ack = 1'b0;
    logic [63:0]       mem_rdata = '0;
    logic              dev_valid, dev_take;
    logic [63:0]       dev_data;
    logic [63:0]       dev_rdata = '0;
    logic              busy, done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_dma #(.LEN_W(LEN_W)) u_seg_dma (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xfer_len(xfer_len),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .dev_valid(dev_valid), .dev_data(dev_data),
        .dev_take(dev_take), .dev_rdata(dev_rdata), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mdat(int b);
        return {32'hA5A5_0000 + 32'(b), 32'h0F0F_0000 + 32'(b)};
    endfunction

    function automatic logic [63:0] ddat(int b);
        return {32'h5A5A_0000 + 32'(b), 32'hF0F0_0000 + 32'(b)};
    endfunction

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic start_xfer(input int d, input int w, input int inc,
                              input int len, input logic [63:0] base);
        wr(3'd0, (32'(d) << 16) | (32'(w) << 4) | 32'(inc));
        wr(3'd3, base[31:0]);
        wr(3'd4, base[63:32]);
        xfer_len = LEN_W'(len);
        wr(3'd1, 32'd1);
    endtask

    task automatic run_loop(input int d, input int w, input int inc,
                            input int len, input logic [63:0] base, input int pat);
        int size = 1 << w;
        int exp_beats = (len + size - 1) / size;
        int beats = 0;
        bit got_done = 0;
        for (int cyc = 0; cyc < 300; cyc++) begin
            mem_ack = 1'b0;
            if (done) begin got_done = 1; break; end
            if (!mem_req) begin
                chk(0, "R5", "request missing before done", 0, 1);
                break;
            end else begin
                bit ack;
                logic [63:0] ea;
                ea = base + (inc != 0 ? 64'(beats * size) : 64'd0);
                chk(mem_addr == ea, inc != 0 ? "R2" : "R3", "beat address", mem_addr, ea);
                chk(mem_size == 2'(w), "R2", "size code", 64'(mem_size), 64'(w));
                chk(mem_we == d[0], "R1", "direction", 64'(mem_we), 64'(d));
                ack = (pat == 0) || (pat == 1 && cyc[0]) || (pat == 2 && (cyc % 3 == 2));
                mem_ack = ack; mem_rdata = mdat(beats); dev_rdata = ddat(beats);
                #1;
                if (ack) begin
                    if (d == 0) begin
                        chk(dev_valid && !dev_take, "R10", "dev_valid on read beat",
                            64'(dev_valid), 1);
                        chk(dev_data == mdat(beats), "R10", "dev_data", dev_data, mdat(beats));
                    end else begin
                        chk(dev_take && !dev_valid, "R10", "dev_take on write beat",
                            64'(dev_take), 1);
                        chk(mem_wdata == ddat(beats), "R10", "mem_wdata", mem_wdata, ddat(beats));
                    end
                    beats++;
                end
            end
            @(negedge clk);
        end
        mem_ack = 1'b0;
        chk(got_done == 1, "R5", "done pulse seen", 64'(got_done), 1);
        chk(beats == exp_beats, "R5", "beat count", 64'(beats), 64'(exp_beats));
        chk(!busy && !mem_req, "R5", "idle with done", 64'(busy), 0);
        @(negedge clk);
        chk(!done && !busy, "R5", "done lasts one cycle", 64'(done), 0);
    endtask

    task automatic expect_quiet(input string req, input int n);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            if (busy || mem_req || done) seen = 1;
            @(negedge clk);
        end
        chk(!seen, req, "ignored start stays quiet", 64'(seen), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [63:0] base;
        base = 64'h0000_0012_3456_7800;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        chk(!busy && !done && !mem_req, "R5", "reset outputs", 64'(busy), 0);
        rd(3'd0, r); chk(r == 0, "R1", "mode reset", 64'(r), 0);
        rd(3'd1, r); chk(r == 0, "R4", "ctrl reset", 64'(r), 0);
        rd(3'd2, r); chk(r == 32'h300, "R7", "chan reset value", 64'(r), 64'h300);
        rd(3'd3, r); chk(r == 0, "R8", "addr low reset", 64'(r), 0);
        rd(3'd4, r); chk(r == 0, "R8", "addr high reset", 64'(r), 0);
        @(negedge clk);

        // register readback
        wr(3'd0, 32'h0003_0031);
        rd(3'd0, r); chk(r == 32'h0003_0031, "R1", "mode readback", 64'(r), 64'h30031);
        wr(3'd3, 32'hDEAD_BEE8); wr(3'd4, 32'h0000_00C0);
        rd(3'd3, r); chk(r == 32'hDEAD_BEE8, "R8", "addr low readback", 64'(r), 64'hDEADBEE8);
        rd(3'd4, r); chk(r == 32'h0000_00C0, "R8", "addr high readback", 64'(r), 64'hC0);
        @(negedge clk);

        // sweep direction x size x increment x length x ack pattern
        for (int d = 0; d < 2; d++)
            for (int w = 0; w < 4; w++)
                for (int inc = 0; inc < 2; inc++)
                    for (int li = 0; li < 3; li++) begin
                        int size = 1 << w;
                        int len = (li == 0) ? 0 : (li == 1) ? size : 3 * size + 1;
                        int pat = (d + w + inc + li) % 3;
                        start_xfer(d, w, inc, len, base);
                        rd(3'd1, r);
                        chk(r == 0, "R4", "start bit self-clears", 64'(r), 0);
                        run_loop(d, w, inc, len, base, pat);
                    end

        // start while busy is ignored
        start_xfer(0, 3, 1, 24, base);
        wr(3'd0, 32'h0001_0000);
        wr(3'd3, 32'h0000_1001);
        xfer_len = 16'd2;
        wr(3'd1, 32'd1);
        chk(busy, "R6", "still busy after second start", 64'(busy), 1);
        run_loop(0, 3, 1, 24, base, 0);

        // channel held in reset blocks its start, other channel runs
        wr(3'd2, 32'h0000_0100);
        start_xfer(1, 2, 1, 8, base);
        expect_quiet("R7", 4);
        start_xfer(0, 2, 1, 8, base);
        run_loop(0, 2, 1, 8, base, 0);
        wr(3'd2, 32'h0000_0300);

        // abort by clearing the running channel's bit
        start_xfer(0, 2, 1, 64, base);
        mem_ack = 1'b1;
        @(negedge clk); @(negedge clk);
        mem_ack = 1'b0;
        chk(mem_addr == base + 64'd8, "R2", "address after two beats", mem_addr, base + 64'd8);
        wr(3'd2, 32'h0000_0200);
        @(negedge clk);
        chk(!busy && !mem_req && !done, "R7", "abort stops transfer", 64'(busy), 0);
        expect_quiet("R7", 4);
        wr(3'd2, 32'h0000_0300);
        start_xfer(1, 1, 0, 4, base);
        run_loop(1, 1, 0, 4, base, 1);

        // misaligned starts are ignored
        start_xfer(0, 3, 1, 16, base + 64'd4);
        expect_quiet("R9", 4);
        start_xfer(1, 1, 1, 4, base + 64'd1);
        expect_quiet("R9", 4);
        start_xfer(0, 2, 1, 8, base + 64'd2);
        expect_quiet("R9", 4);
        start_xfer(0, 0, 1, 3, base + 64'd1);
        run_loop(0, 0, 1, 3, base + 64'd1, 2);

        // only bit 16 of the direction field is decoded
        start_xfer(2, 2, 1, 8, base);
        run_loop(0, 2, 1, 8, base, 0);
        start_xfer(3, 2, 1, 8, base);
        run_loop(1, 2, 1, 8, base, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule